// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Decoder

This block turns aligned 5-bit code groups, one per receive clock, into the receive side of a media independent interface. It produces a 4-bit nibble, carrier sense, data valid and receive error. In 100 Mb/s operation it decodes 4B/5B symbols. A frame opens on the start delimiter pair /J/ then /K/ and closes on the end pair /T/ then /R/. Invalid code groups and broken delimiters are reported on the error output. Clock recovery, line decoding, descrambling, symbol alignment, collision handling and the transmit path belong to other blocks.

A mode input selects 10 Mb/s operation instead. In that mode carrier sense is set by a preamble-confirmed strobe and cleared by an idle-confirmed strobe. Data valid copies carrier sense, and the low four bits of the symbol input are passed through as the nibble. All outputs are registered, so each output reflects the input of the previous clock. A synchronous active-high reset returns the block to idle search.

Top module: `rx_symbol_decoder`

## Requirements
- R1: While `rst` is high, every output is 0 one clock later, and a frame in progress is abandoned.
- R2: In 100 Mb/s mode (`mode_100`=1), `mii_crs` one clock after a code group is 1 exactly when that group is not IDLE (11111).
- R3: From idle search, J (11000) yields crs=1, dv=0, rxd=0101. A following K (10001) yields crs=1, dv=1, rxd=0101. Data valid rises only on K.
- R4: Inside a frame, each of the 16 data code groups yields dv=1, er=0 and its 4B/5B nibble one clock later. The codes for nibbles 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: T (01101) inside a frame yields crs=1, dv=0, er=0, rxd=0000. A following R (00111) yields the same, and IDLE afterwards brings all outputs to 0.
- R6: Inside a frame, a code group that is neither data, T nor IDLE (an invalid code, J, K or R) yields dv=1, er=1, rxd=1110 for that clock only, and the frame continues.
- R7: From idle search, a non-IDLE group other than J, or a group other than K or IDLE after J, is a false carrier. It yields crs=1, dv=0, er=1, rxd=1110 for every group until IDLE, which yields all zeros.
- R8: After T, a group other than R is a malformed end. It yields er=1 and rxd=1110 with dv=0, and crs follows R2. IDLE returns to idle search, and any other group enters the false-carrier state.
- R9: IDLE inside a frame ends it at once with all outputs 0.
- R10: In 10 Mb/s mode, `mii_crs` becomes 1 the clock after `pre_ok` and 0 the clock after `idle_ok`; `idle_ok` wins when both are high.
- R11: In 10 Mb/s mode, `mii_dv` equals `mii_crs`, `mii_er` is 0, and `mii_rxd` is the previous `sym_in[3:0]` while carrier is set, otherwise 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_100 | input | 1 | 1: 100 Mb/s symbol decoding, 0: 10 Mb/s strobe mode |
| sym_in | input | 5 | Aligned code group (10 Mb/s: low four bits are the nibble) |
| pre_ok | input | 1 | 10 Mb/s preamble-confirmed strobe |
| idle_ok | input | 1 | 10 Mb/s idle-confirmed strobe |
| mii_rxd | output | 4 | Receive nibble |
| mii_crs | output | 1 | Carrier sense |
| mii_dv | output | 1 | Receive data valid |
| mii_er | output | 1 | Receive error |

## Verification
The properties assume that `sym_in` holds one stable code group per clock and that the mode input is sampled on the same edge as the symbol. In that case carrier sense, the start delimiter and the error nibble depend only on the previous clock's inputs. They also assume the strobes carry meaning only in 10 Mb/s mode. The stimulus changes every input on the falling edge, so each group is held for a whole clock. The mode is switched only while the line is idle. Sweeps offer all 32 code groups as the first symbol, as the symbol after J and as a symbol inside a frame.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] C_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] C_J    = 5'b11000;
  localparam logic [SYM_W-1:0] C_K    = 5'b10001;
  localparam logic [SYM_W-1:0] C_T    = 5'b01101;
  localparam logic [SYM_W-1:0] C_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_ERR = 4'b1110;

  typedef enum logic [2:0] {
    SC_DATA, SC_IDLE, SC_J, SC_K, SC_T, SC_R, SC_BAD
  } sym_cls_t;

  typedef enum logic [2:0] {
    ST_HUNT, ST_GOT_J, ST_FRAME, ST_GOT_T, ST_TAIL, ST_FALSE
  } rx_state_t;

  typedef struct packed {
    logic             crs;
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] rxd;
  } mii_word_t;
endpackage

// File: rtl/rxdec_sym_lut.sv
module rxdec_sym_lut
  import rxdec_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  output sym_cls_t         cls,
  output logic [NIB_W-1:0] nib
);
  always_comb begin
    cls = SC_DATA;
    nib = '0;
    unique case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      C_IDLE:   cls = SC_IDLE;
      C_J:      cls = SC_J;
      C_K:      cls = SC_K;
      C_T:      cls = SC_T;
      C_R:      cls = SC_R;
      default:  cls = SC_BAD;
    endcase
  end
endmodule

// File: rtl/rxdec_frame_fsm.sv
module rxdec_frame_fsm
  import rxdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  sym_cls_t         cls,
  input  logic [NIB_W-1:0] nib,
  output mii_word_t        nxt
);
  rx_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    nxt     = '0;
    nxt.crs = (cls != SC_IDLE);
    unique case (state_q)
      ST_HUNT: begin
        if (cls == SC_J) begin
          nxt.rxd = NIB_PRE;
          state_d = ST_GOT_J;
        end else if (cls != SC_IDLE) begin
          nxt.er  = 1'b1;
          nxt.rxd = NIB_ERR;
          state_d = ST_FALSE;
        end
      end
      ST_GOT_J: begin
        if (cls == SC_K) begin
          nxt.dv  = 1'b1;
          nxt.rxd = NIB_PRE;
          state_d = ST_FRAME;
        end else if (cls == SC_IDLE) begin
          state_d = ST_HUNT;
        end else begin
          nxt.er  = 1'b1;
          nxt.rxd = NIB_ERR;
          state_d = ST_FALSE;
        end
      end
      ST_FRAME: begin
        if (cls == SC_DATA) begin
          nxt.dv  = 1'b1;
          nxt.rxd = nib;
        end else if (cls == SC_T) begin
          state_d = ST_GOT_T;
        end else if (cls == SC_IDLE) begin
          state_d = ST_HUNT;
        end else begin
          nxt.dv  = 1'b1;
          nxt.er  = 1'b1;
          nxt.rxd = NIB_ERR;
        end
      end
      ST_GOT_T: begin
        if (cls == SC_R) begin
          state_d = ST_TAIL;
        end else begin
          nxt.er  = 1'b1;
          nxt.rxd = NIB_ERR;
          state_d = (cls == SC_IDLE) ? ST_HUNT : ST_FALSE;
        end
      end
      ST_TAIL: begin
        if (cls == SC_IDLE) state_d = ST_HUNT;
      end
      ST_FALSE: begin
        if (cls == SC_IDLE) begin
          state_d = ST_HUNT;
        end else begin
          nxt.er  = 1'b1;
          nxt.rxd = NIB_ERR;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) state_q <= ST_HUNT;
    else            state_q <= state_d;
  end
endmodule

// File: rtl/rxdec_carrier10.sv
module rxdec_carrier10
  import rxdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pre_ok,
  input  logic             idle_ok,
  input  logic [NIB_W-1:0] nib_in,
  output mii_word_t        nxt
);
  logic carrier_q, carrier_d;

  always_comb begin
    carrier_d = carrier_q;
    if (idle_ok)     carrier_d = 1'b0;
    else if (pre_ok) carrier_d = 1'b1;
    nxt.crs = carrier_d;
    nxt.dv  = carrier_d;
    nxt.er  = 1'b0;
    nxt.rxd = carrier_d ? nib_in : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) carrier_q <= 1'b0;
    else            carrier_q <= carrier_d;
  end
endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
  import rxdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_100,
  input  logic [SYM_W-1:0] sym_in,
  input  logic             pre_ok,
  input  logic             idle_ok,
  output logic [NIB_W-1:0] mii_rxd,
  output logic             mii_crs,
  output logic             mii_dv,
  output logic             mii_er
);
  sym_cls_t         cls;
  logic [NIB_W-1:0] nib;
  mii_word_t        fast_nxt, slow_nxt, out_q;

  rxdec_sym_lut lut_i (
    .code (sym_in),
    .cls  (cls),
    .nib  (nib)
  );

  rxdec_frame_fsm fsm_i (
    .clk  (clk),
    .rst  (rst),
    .en   (mode_100),
    .cls  (cls),
    .nib  (nib),
    .nxt  (fast_nxt)
  );

  rxdec_carrier10 c10_i (
    .clk     (clk),
    .rst     (rst),
    .en      (!mode_100),
    .pre_ok  (pre_ok),
    .idle_ok (idle_ok),
    .nib_in  (sym_in[NIB_W-1:0]),
    .nxt     (slow_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)           out_q <= '0;
    else if (mode_100) out_q <= fast_nxt;
    else               out_q <= slow_nxt;
  end

  assign mii_rxd = out_q.rxd;
  assign mii_crs = out_q.crs;
  assign mii_dv  = out_q.dv;
  assign mii_er  = out_q.er;
endmodule

// File: rtl/rxdec_checker.sv
module rxdec_checker
  import rxdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             mode_100,
  input logic [SYM_W-1:0] sym_in,
  input logic [NIB_W-1:0] mii_rxd,
  input logic             mii_crs,
  input logic             mii_dv,
  input logic             mii_er
);
  AST_CRS_TRACKS_IDLE: assert property (@(posedge clk) disable iff (rst)
    mode_100 |=> (mii_crs == ($past(sym_in) != C_IDLE))); // R2

  AST_DV_RISES_ON_K: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_100) && $rose(mii_dv)) |-> ($past(sym_in) == C_K && mii_rxd == NIB_PRE)); // R3

  AST_DV_NEEDS_CRS: assert property (@(posedge clk) disable iff (rst)
    mii_dv |-> mii_crs); // R3

  AST_ERR_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    mii_er |-> (mii_rxd == NIB_ERR)); // R6

  AST_SLOW_DV_EQ_CRS: assert property (@(posedge clk) disable iff (rst)
    !mode_100 |=> (mii_dv == mii_crs)); // R11

  AST_SLOW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !mode_100 |=> !mii_er); // R11
endmodule

bind rx_symbol_decoder rxdec_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_100 (mode_100),
  .sym_in   (sym_in),
  .mii_rxd  (mii_rxd),
  .mii_crs  (mii_crs),
  .mii_dv   (mii_dv),
  .mii_er   (mii_er)
);

// File: tb/rx_symbol_decoder_tb_top.sv
`timescale 1ns/1ps
module rx_symbol_decoder_tb_top;
  localparam logic [4:0] IDL = 5'b11111, SJ = 5'b11000, SK = 5'b10001,
                         ST = 5'b01101, SR = 5'b00111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_100 = 1'b1;
  logic [4:0] sym_in = IDL;
  logic       pre_ok = 1'b0;
  logic       idle_ok = 1'b0;
  logic [3:0] mii_rxd;
  logic       mii_crs, mii_dv, mii_er;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rx_symbol_decoder dut_i (
    .clk(clk), .rst(rst), .mode_100(mode_100), .sym_in(sym_in),
    .pre_ok(pre_ok), .idle_ok(idle_ok), .mii_rxd(mii_rxd),
    .mii_crs(mii_crs), .mii_dv(mii_dv), .mii_er(mii_er)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100;
      4'h3: enc = 5'b10101; 4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111; 4'h8: enc = 5'b10010;
      4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100;
      default: enc = 5'b11101;
    endcase
  endfunction

  function automatic int dec(input logic [4:0] c);
    dec = -1;
    for (int n = 0; n < 16; n++) if (enc(4'(n)) == c) dec = n;
  endfunction

  task automatic step(input logic [4:0] s);
    sym_in = s;
    @(negedge clk);
  endtask

  task automatic expect_o(input string tag, input logic c, input logic d,
                          input logic e, input logic [3:0] r);
    n_chk++;
    if (mii_crs !== c || mii_dv !== d || mii_er !== e || mii_rxd !== r) begin
      n_bad++;
      $display("FAIL %s sym=%b: got crs=%b dv=%b er=%b rxd=%h, exp crs=%b dv=%b er=%b rxd=%h",
               tag, sym_in, mii_crs, mii_dv, mii_er, mii_rxd, c, d, e, r);
    end
  endtask

  task automatic expect_crs(input string tag, input logic c);
    n_chk++;
    if (mii_crs !== c) begin
      n_bad++;
      $display("FAIL %s: got crs=%b, exp crs=%b", tag, mii_crs, c);
    end
  endtask

  task automatic open_frame();
    step(IDL); step(SJ); step(SK);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_o("R1 reset", 0, 0, 0, 4'h0);
    rst = 1'b0;
    step(IDL); expect_o("R2 idle line", 0, 0, 0, 4'h0);

    // R3 R4 R5: full frame for each nibble
    for (int n = 0; n < 16; n++) begin
      step(IDL);
      step(SJ);  expect_o("R3 J", 1, 0, 0, 4'h5);
      step(SK);  expect_o("R3 K", 1, 1, 0, 4'h5);
      step(enc(4'(n))); expect_o("R4 data", 1, 1, 0, 4'(n));
      step(ST);  expect_o("R5 T", 1, 0, 0, 4'h0);
      step(SR);  expect_o("R5 R", 1, 0, 0, 4'h0);
      step(IDL); expect_o("R5 idle", 0, 0, 0, 4'h0);
    end

    // R1: reset abandons a frame
    open_frame(); step(enc(4'h3));
    rst = 1'b1; step(enc(4'h4)); expect_o("R1 mid-frame reset", 0, 0, 0, 4'h0);
    rst = 1'b0; step(enc(4'h4)); expect_o("R1 hunt after reset", 1, 0, 1, 4'hE);
    step(IDL);

    // all 32 groups inside a frame
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cc = 5'(c);
      open_frame();
      step(cc);
      if (dec(cc) >= 0)    expect_o("R4 in-frame data", 1, 1, 0, 4'(dec(cc)));
      else if (cc == IDL)  expect_o("R9 idle ends frame", 0, 0, 0, 4'h0);
      else if (cc == ST)   expect_o("R5 T in sweep", 1, 0, 0, 4'h0);
      else begin
        expect_o("R6 bad in frame", 1, 1, 1, 4'hE);
        step(enc(4'h9)); expect_o("R6 frame continues", 1, 1, 0, 4'h9);
      end
      step(IDL); expect_crs("R2 idle drops crs", 0);
      step(IDL); expect_o("R9 back to idle", 0, 0, 0, 4'h0);
    end

    // all 32 groups as first symbol
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cc = 5'(c);
      step(IDL); step(cc);
      if (cc == IDL)     expect_o("R2 idle first", 0, 0, 0, 4'h0);
      else if (cc == SJ) expect_o("R3 J first", 1, 0, 0, 4'h5);
      else begin
        expect_o("R7 false carrier", 1, 0, 1, 4'hE);
        step(SK); expect_o("R7 false carrier holds", 1, 0, 1, 4'hE);
      end
      step(IDL); expect_o("R7 idle clears", 0, 0, 0, 4'h0);
    end

    // all 32 groups after J
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cc = 5'(c);
      step(IDL); step(SJ); step(cc);
      if (cc == SK)       expect_o("R3 K after J", 1, 1, 0, 4'h5);
      else if (cc == IDL) expect_o("R7 idle after J", 0, 0, 0, 4'h0);
      else                expect_o("R7 bad J/K pair", 1, 0, 1, 4'hE);
      step(IDL); step(IDL); expect_o("R7 recover", 0, 0, 0, 4'h0);
    end

    // R8 malformed end
    open_frame(); step(ST); step(enc(4'h0));
    expect_o("R8 T then data", 1, 0, 1, 4'hE);
    step(enc(4'h1)); expect_o("R8 false after bad end", 1, 0, 1, 4'hE);
    step(IDL); expect_o("R8 idle clears", 0, 0, 0, 4'h0);
    open_frame(); step(ST); step(IDL);
    expect_o("R8 T then idle", 0, 0, 1, 4'hE);
    step(IDL); expect_o("R8 settled", 0, 0, 0, 4'h0);

    // R10 R11: 10 Mb/s mode
    mode_100 = 1'b0;
    step(5'h1A); expect_o("R11 no carrier", 0, 0, 0, 4'h0);
    pre_ok = 1'b1; step(5'h13); pre_ok = 1'b0;
    expect_o("R10 preamble sets crs", 1, 1, 0, 4'h3);
    for (int n = 0; n < 16; n++) begin
      step(5'(n) | 5'h10);
      expect_o("R11 nibble passthrough", 1, 1, 0, 4'(n));
    end
    step(IDL); expect_o("R11 IDLE code ignored", 1, 1, 0, 4'hF);
    idle_ok = 1'b1; step(5'h05); idle_ok = 1'b0;
    expect_o("R10 idle clears crs", 0, 0, 0, 4'h0);
    pre_ok = 1'b1; idle_ok = 1'b1; step(5'h07);
    expect_o("R10 idle wins", 0, 0, 0, 4'h0);
    idle_ok = 1'b0; step(5'h07); pre_ok = 1'b0;
    expect_o("R10 set again", 1, 1, 0, 4'h7);
    step(5'h02); expect_o("R10 held", 1, 1, 0, 4'h2);
    idle_ok = 1'b1; step(IDL); idle_ok = 1'b0;
    mode_100 = 1'b1;
    step(IDL); expect_o("R2 back to 100", 0, 0, 0, 4'h0);
    step(SJ);  expect_o("R3 J after mode change", 1, 0, 0, 4'h5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule